// File: doc/BRIEF.md
# Image Resize Coefficient Calculator

This unit turns a pair of image sizes per axis into the settings a scaler needs. For each axis it receives a source length and a destination length. It checks that the pair is within the supported range. It then decides how many times the source should be halved by a power-of-two pre-decimator, and works out a fixed-point step ratio for the fine resampler. The vertical axis is handled first and the horizontal axis second. Both results go into one 32-bit configuration word.

A controller pulses `start` with the four sizes on the inputs and waits for the one-cycle `done` pulse. At that pulse, `cfg_word`, `err` and `ovf` are valid, and they stay as they are until the next completion. While a computation is running, further `start` pulses are dropped. The ratio comes from a restoring divider that produces one quotient bit per clock, so each axis takes a few tens of cycles.

Top module: `rsz_coef_calc`

## Requirements
- R1: If either axis has a source length above 4096 or a destination length above 1024, the request completes with `err`=1.
- R2: If either axis has destination*8 < source (a reduction steeper than 8:1), the request completes with `err`=1.
- R3: The per-axis halving code starts at 0. While the working length is above 1024, or is at least twice the destination, the length is halved (floor) and the code is incremented, with at most 2 halvings. The code is therefore 0, 1 or 2 and never 3.
- R4: The per-axis ratio is floor(8192*(reduced_length-1)/(destination-1)).
- R5: A ratio of 16384 or more is replaced by 0x3FFF. When either axis saturates on a successful request, `ovf`=1 at completion; otherwise `ovf`=0.
- R6: `cfg_word` holds the vertical halving code in bits [31:30], the vertical ratio in [29:16], the horizontal halving code in [15:14] and the horizontal ratio in [13:0].
- R7: The vertical axis is checked and computed before the horizontal axis. An error on either axis finishes the request with `err`=1 and `ovf`=0, and `cfg_word` keeps its previous value.
- R8: A destination length below 2, or a source length of 0, on either axis is an error (`err`=1), so the divider never divides by zero.
- R9: A `start` pulse that arrives while a request is in progress is ignored: the result and the number of `done` pulses are those of the first request.
- R10: `done` is high for exactly one cycle per accepted request, after both axes have finished or after an error. After reset, `done`, `err` and `ovf` are 0 and `cfg_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request; sizes are sampled on the same cycle |
| v_in | input | 13 | Vertical source length |
| v_out | input | 11 | Vertical destination length |
| h_in | input | 13 | Horizontal source length |
| h_out | input | 11 | Horizontal destination length |
| done | output | 1 | One-cycle completion pulse |
| cfg_word | output | 32 | Packed halving codes and ratios |
| err | output | 1 | Last request was rejected |
| ovf | output | 1 | Last successful request saturated a ratio |

## Verification
On every cycle, the assertions check the following: `done` lasts one cycle; a rejected request leaves `cfg_word` unchanged and never also reports overflow; `ovf` only appears when a ratio field reads 0x3FFF; no halving code of 3 is produced; and the latched sizes stay put while a busy unit sees `start`. The bench scenarios cover everything that depends on arithmetic or ordering. These are the exact ratio values, the halving counts near the 2x and 8:1 edges and at the 4096/1024 limits, the rejection classes, the bit packing with different axis values, and the dropped intrusive start. The bench compares each of these against a model computed from the requirements.

// File: rtl/rsz_coef_calc.sv
module rsz_coef_calc #(
  parameter int IN_W    = 13,
  parameter int OUT_W   = 11,
  parameter int MAX_IN  = 4096,
  parameter int MAX_OUT = 1024,
  parameter int FRAC    = 13,
  parameter int COEF_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [IN_W-1:0]         v_in,
  input  logic [OUT_W-1:0]        v_out,
  input  logic [IN_W-1:0]         h_in,
  input  logic [OUT_W-1:0]        h_out,
  output logic                    done,
  output logic [2*(COEF_W+2)-1:0] cfg_word,
  output logic                    err,
  output logic                    ovf
);

  localparam int X_W     = IN_W + 4;
  localparam int FIELD_W = COEF_W + 2;
  localparam int NUM_W   = FRAC + $clog2(MAX_OUT);
  localparam int REM_W   = OUT_W + 1;
  localparam int CNT_W   = $clog2(NUM_W + 1);
  localparam logic [X_W-1:0]    LIM_IN  = X_W'(MAX_IN);
  localparam logic [X_W-1:0]    LIM_OUT = X_W'(MAX_OUT);
  localparam logic [X_W-1:0]    ONE_X   = X_W'(1);
  localparam logic [X_W-1:0]    TWO_X   = X_W'(2);
  localparam logic [COEF_W-1:0] SAT     = {COEF_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIV, S_NEXT} state_t;

  state_t               state_q;
  logic                 axis_q;
  logic [IN_W-1:0]      vi_q, hi_q;
  logic [OUT_W-1:0]     vo_q, ho_q;
  logic [1:0]           code_q;
  logic [FIELD_W-1:0]   vfield_q;
  logic                 vsat_q;
  logic [REM_W-1:0]     rem_q, div_q;
  logic [NUM_W-1:0]     quo_q;
  logic [CNT_W-1:0]     cnt_q;

  logic [X_W-1:0] in_x, out_x, t1, t2;
  logic           bad, c1, c2;
  logic [1:0]     code;

  assign in_x  = axis_q ? X_W'(hi_q) : X_W'(vi_q);
  assign out_x = axis_q ? X_W'(ho_q) : X_W'(vo_q);

  assign bad = (in_x > LIM_IN) || (out_x > LIM_OUT) || (out_x < TWO_X) ||
               (in_x == '0) || ((out_x << 3) < in_x);

  assign c1   = (in_x > LIM_OUT) || (in_x >= (out_x << 1));
  assign t1   = c1 ? (in_x >> 1) : in_x;
  assign c2   = c1 && ((t1 > LIM_OUT) || (t1 >= (out_x << 1)));
  assign t2   = c2 ? (t1 >> 1) : t1;
  assign code = {c2, c1 & ~c2};

  logic [REM_W-1:0] shifted;
  logic [REM_W:0]   diff;
  assign shifted = {rem_q[REM_W-2:0], quo_q[NUM_W-1]};
  assign diff    = {1'b0, shifted} - {1'b0, div_q};

  logic              sat;
  logic [COEF_W-1:0] coef;
  assign sat  = |quo_q[NUM_W-1:COEF_W];
  assign coef = sat ? SAT : quo_q[COEF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      axis_q   <= 1'b0;
      vi_q     <= '0;
      vo_q     <= '0;
      hi_q     <= '0;
      ho_q     <= '0;
      code_q   <= '0;
      vfield_q <= '0;
      vsat_q   <= 1'b0;
      rem_q    <= '0;
      div_q    <= '0;
      quo_q    <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
      cfg_word <= '0;
      err      <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          vi_q    <= v_in;
          vo_q    <= v_out;
          hi_q    <= h_in;
          ho_q    <= h_out;
          axis_q  <= 1'b0;
          state_q <= S_LOAD;
        end
        S_LOAD: if (bad) begin
          done    <= 1'b1;
          err     <= 1'b1;
          ovf     <= 1'b0;
          state_q <= S_IDLE;
        end else begin
          rem_q   <= '0;
          quo_q   <= NUM_W'(t2 - ONE_X) << FRAC;
          div_q   <= REM_W'(out_x - ONE_X);
          cnt_q   <= CNT_W'(NUM_W);
          code_q  <= code;
          state_q <= S_DIV;
        end
        S_DIV: begin
          if (!diff[REM_W]) rem_q <= diff[REM_W-1:0];
          else              rem_q <= shifted;
          quo_q <= {quo_q[NUM_W-2:0], ~diff[REM_W]};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= S_NEXT;
        end
        S_NEXT: if (!axis_q) begin
          vfield_q <= {code_q, coef};
          vsat_q   <= sat;
          axis_q   <= 1'b1;
          state_q  <= S_LOAD;
        end else begin
          cfg_word <= {vfield_q, code_q, coef};
          ovf      <= vsat_q | sat;
          err      <= 1'b0;
          done     <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_word_kept_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(cfg_word) && !ovf));

  assert_ovf_needs_sat_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (cfg_word[2*FIELD_W-3 -: COEF_W] == SAT || cfg_word[COEF_W-1:0] == SAT));

  assert_code_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (cfg_word[2*FIELD_W-1 -: 2] != 2'd3 && cfg_word[FIELD_W-1 -: 2] != 2'd3));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && start) |=> ($stable(vi_q) && $stable(vo_q) && $stable(hi_q) && $stable(ho_q)));

endmodule

// File: tb/rsz_coef_calc_tb_top.sv
module rsz_coef_calc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] v_in = '0, h_in = '0;
  logic [10:0] v_out = '0, h_out = '0;
  logic        done, err, ovf;
  logic [31:0] cfg_word;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_word = '0;
  logic [33:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsz_coef_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .v_in(v_in), .v_out(v_out), .h_in(h_in), .h_out(h_out),
    .done(done), .cfg_word(cfg_word), .err(err), .ovf(ovf)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, expv);
    end
  endtask

  task automatic axis_model(input int si, input int so, output bit bad, output bit s, output logic [15:0] field);
    int t, k, c;
    bad = (si > 4096) || (so > 1024) || (so < 2) || (si == 0) || (so * 8 < si);
    t = si; k = 0; field = '0; s = 1'b0;
    if (bad) return;
    while (((t > 1024) || (t >= 2 * so)) && (k < 2)) begin
      t = t >> 1;
      k++;
    end
    c = (8192 * (t - 1)) / (so - 1);
    s = (c >= 16384);
    if (s) c = 16383;
    field = {k[1:0], c[13:0]};
  endtask

  task automatic push_expect(input int vi, input int vo, input int hi, input int ho, input string tag);
    bit vb, hb, vs, hs;
    logic [15:0] vf, hf;
    axis_model(vi, vo, vb, vs, vf);
    axis_model(hi, ho, hb, hs, hf);
    if (vb || hb) exp_q.push_back({1'b1, 1'b0, last_word});
    else begin
      last_word = {vf, hf};
      exp_q.push_back({1'b0, vs | hs, last_word});
    end
    tag_q.push_back(tag);
  endtask

  task automatic pulse(input int vi, input int vo, input int hi, input int ho);
    @(negedge clk);
    v_in = 13'(vi); v_out = 11'(vo); h_in = 13'(hi); h_out = 11'(ho);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input int vi, input int vo, input int hi, input int ho, input string tag);
    push_expect(vi, vo, hi, ho, tag);
    pulse(vi, vo, hi, ho);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected done: actual 1 expected 0");
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "cfg_word", cfg_word, e[31:0]);
        check(t, "err", {31'd0, err}, {31'd0, e[33]});
        check(t, "ovf", {31'd0, ovf}, {31'd0, e[32]});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "reset done", {31'd0, done}, 32'd0);
    check("R10", "reset word", cfg_word, 32'd0);
    check("R10", "reset err", {31'd0, err}, 32'd0);
    check("R10", "reset ovf", {31'd0, ovf}, 32'd0);

    run(640, 640, 640, 640, "R4 unity");
    run(100, 400, 100, 400, "R4 upscale");
    run(800, 400, 801, 400, "R3 one halving");
    run(4096, 1024, 4096, 1024, "R3 two halvings at limits");
    run(2000, 250, 300, 200, "R5 saturate vertical");
    run(480, 240, 720, 1000, "R6 packing");
    run(2001, 250, 640, 640, "R2 steeper than 8:1");
    run(4097, 1024, 640, 640, "R1 source limit");
    run(640, 640, 1025, 1025, "R1 destination limit");
    run(640, 1, 640, 640, "R8 destination one");
    run(640, 640, 0, 640, "R8 source zero");
    run(640, 640, 900, 100, "R7 horizontal error keeps word");
    run(123, 45, 333, 1024, "R4 mixed");

    push_expect(300, 200, 500, 300, "R9 busy start ignored");
    pulse(300, 200, 500, 300);
    repeat (4) @(negedge clk);
    pulse(640, 640, 640, 640);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (80) @(negedge clk);
    check("R9", "extra done count", 32'(exp_q.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule